// File: doc/BRIEF.md
# Boot Sequence Controller

This block runs the fixed start-up script of a small processor after a boot request. A request may arrive as a one-cycle pulse from a hardware button or as a one-cycle pulse from a software boot command. Both enter the same path. The controller then carries out four steps over a single-word memory bus:

1. It stores the program counter, captured when the script starts, at word 0.
2. It writes zero to the display control word, which blanks the screen.
3. It pulses an interrupt-disable line.
4. It reads the keyboard word to choose the boot type and the disk address.

The memory bus has a request channel and a read response channel, and both use valid/ready. A request keeps its address, write flag and write data unchanged until the memory raises ready. The memory may hold ready low for any number of cycles, and the controller waits. Only the keyboard read produces a response. The controller raises response-ready while it waits for that word, so the memory decides when the response arrives. At the end of the script the controller gives a one-cycle done pulse. The boot type and disk address are presented on output registers, which stay unchanged until the next done pulse.

Keys are active low: a key that is held reads as 0. The disk address is the inverse of the keyboard word. The decision rests on one boot-select key bit, whose position is a parameter. The controller writes no memory word other than the two named above, so the processor's registers are left alone.

Top module: `boot_seq`

## Requirements
- R1: After reset the request valid, interrupt-disable and done outputs are low, and the boot type and disk address outputs are 0.
- R2: A pulse on either boot input starts the same script. Its first step writes the program counter, sampled when the script starts, to address 0.
- R3: The second step writes the value 0 to the display control address, octal 420 (0x0110).
- R4: Once the display write is accepted, the interrupt-disable output is high for exactly one cycle, and this comes before the keyboard read request is issued.
- R5: The fourth step is a read request (write flag low) of the keyboard address, octal 177034 (0xFE1C). Its data is taken from the response channel when response-valid and response-ready are both high.
- R6: When the boot-select key bit (parameter BOOT_KEY_BIT, default 15) reads 1, the boot type is disk (output high) and the disk address is the bitwise inverse of the keyboard word.
- R7: With no key held (keyboard word all ones), the result is a disk boot with disk address 0.
- R8: When the boot-select key bit reads 0, the boot type output is low and the disk address is 0.
- R9: A request stays valid with its address, write flag and data unchanged until ready is seen. The only addresses ever written are 0 and the display control address.
- R10: A boot request that arrives while a script runs lets the open handshake finish, then restarts from step 1 with a freshly sampled program counter. The abandoned run gives no done pulse.
- R11: Done is a single-cycle pulse. The boot type and disk address change only together with done, and they hold their values between pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_btn | input | 1 | Boot pulse from the hardware button |
| boot_cmd | input | 1 | Boot pulse from the software command |
| pc_in | input | DW | Current program counter |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Request word address |
| mem_req_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Controller waits for read data |
| mem_rsp_data | input | DW | Read data |
| irq_off | output | 1 | One-cycle interrupt-disable pulse |
| boot_done | output | 1 | One-cycle end-of-script pulse |
| boot_from_disk | output | 1 | Boot type: 1 = disk boot |
| boot_disk_addr | output | DW | Chosen disk address |

## Verification
The bench checks the order of every bus transfer, interrupt pulse and done pulse against a scoreboard. It does this under memory stalls and with delayed read responses. A design that dropped a held request or changed it while stalled would show a missing or altered transfer. A design that did not invert the keys would report all-ones disk addresses for an idle keyboard. The bench also sends boot requests while the display write is stalled and while the read response is pending. A design that cut a handshake short, kept the old program counter, or still pulsed done for the abandoned run would break the expected order. Inputs with the select key held must yield a zero address, and the outputs must stay unchanged while the block is idle.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_PC,
    ST_WR_DISP,
    ST_IRQ_OFF,
    ST_RD_REQ,
    ST_RD_RSP,
    ST_DONE
  } boot_state_e;
endpackage

// File: rtl/boot_req_latch.sv
module boot_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic req_btn,
  input  logic req_cmd,
  input  logic take,
  output logic pend
);
  logic pend_q;

  // a new request wins over the acceptance of an older one
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= (pend_q & ~take) | req_btn | req_cmd;
  end

  assign pend = pend_q;
endmodule

// File: rtl/boot_step_fsm.sv
module boot_step_fsm
  import boot_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pend,
  input  logic        req_fire,
  input  logic        rsp_fire,
  output boot_state_e state,
  output logic        take,
  output logic        commit
);
  boot_state_e st_q, st_d;
  logic        boundary;

  // points where the script may be restarted without breaking a handshake
  always_comb begin
    case (st_q)
      ST_IDLE, ST_IRQ_OFF, ST_DONE:     boundary = 1'b1;
      ST_WR_PC, ST_WR_DISP, ST_RD_REQ:  boundary = req_fire;
      ST_RD_RSP:                        boundary = rsp_fire;
      default:                          boundary = 1'b0;
    endcase
  end

  assign take   = pend & boundary;
  assign commit = (st_q == ST_DONE) & ~pend;

  always_comb begin
    st_d = st_q;
    if (take) begin
      st_d = ST_WR_PC;
    end else begin
      case (st_q)
        ST_WR_PC:   if (req_fire) st_d = ST_WR_DISP;
        ST_WR_DISP: if (req_fire) st_d = ST_IRQ_OFF;
        ST_IRQ_OFF: st_d = ST_RD_REQ;
        ST_RD_REQ:  if (req_fire) st_d = ST_RD_RSP;
        ST_RD_RSP:  if (rsp_fire) st_d = ST_DONE;
        ST_DONE:    st_d = ST_IDLE;
        default:    st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/boot_bus_drv.sv
module boot_bus_drv
  import boot_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] PC_SAVE_ADDR = '0,
  parameter logic [AW-1:0] DISP_ADDR    = AW'(16'o420),
  parameter logic [AW-1:0] KBD_ADDR     = AW'(16'o177034)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  boot_state_e   state,
  input  logic          take,
  input  logic [DW-1:0] pc_in,
  output logic          req_valid,
  output logic          req_we,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  output logic          rsp_ready,
  output logic          irq_off
);
  logic [DW-1:0] pc_q;

  // program counter is frozen at the moment the script (re)starts
  always_ff @(posedge clk) begin
    if (!rst_n)    pc_q <= '0;
    else if (take) pc_q <= pc_in;
  end

  always_comb begin
    req_valid = 1'b0;
    req_we    = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    case (state)
      ST_WR_PC: begin
        req_valid = 1'b1;
        req_we    = 1'b1;
        req_addr  = PC_SAVE_ADDR;
        req_wdata = pc_q;
      end
      ST_WR_DISP: begin
        req_valid = 1'b1;
        req_we    = 1'b1;
        req_addr  = DISP_ADDR;
      end
      ST_RD_REQ: begin
        req_valid = 1'b1;
        req_addr  = KBD_ADDR;
      end
      default: ;
    endcase
  end

  assign rsp_ready = (state == ST_RD_RSP);
  assign irq_off   = (state == ST_IRQ_OFF);
endmodule

// File: rtl/boot_key_dec.sv
module boot_key_dec #(
  parameter int DW           = 16,
  parameter int BOOT_KEY_BIT = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rsp_fire,
  input  logic [DW-1:0] rsp_data,
  input  logic          commit,
  output logic          done,
  output logic          from_disk,
  output logic [DW-1:0] disk_addr
);
  logic [DW-1:0] kbd_q;
  logic [DW-1:0] addr_d;
  logic          disk_sel;
  logic          done_q;
  logic          disk_q;
  logic [DW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        kbd_q <= '1;
    else if (rsp_fire) kbd_q <= rsp_data;
  end

  // select key released (reads 1) picks the disk path
  assign disk_sel = kbd_q[BOOT_KEY_BIT];

  for (genvar b = 0; b < DW; b++) begin : g_key
    assign addr_d[b] = disk_sel & ~kbd_q[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      disk_q <= 1'b0;
      addr_q <= '0;
    end else begin
      done_q <= commit;
      if (commit) begin
        disk_q <= disk_sel;
        addr_q <= addr_d;
      end
    end
  end

  assign done      = done_q;
  assign from_disk = disk_q;
  assign disk_addr = addr_q;
endmodule

// File: rtl/boot_seq.sv
module boot_seq
  import boot_pkg::*;
#(
  parameter int AW           = 16,
  parameter int DW           = 16,
  parameter int BOOT_KEY_BIT = 15,
  parameter logic [AW-1:0] PC_SAVE_ADDR = '0,
  parameter logic [AW-1:0] DISP_ADDR    = AW'(16'o420),
  parameter logic [AW-1:0] KBD_ADDR     = AW'(16'o177034)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_btn,
  input  logic          boot_cmd,
  input  logic [DW-1:0] pc_in,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  output logic          mem_rsp_ready,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          irq_off,
  output logic          boot_done,
  output logic          boot_from_disk,
  output logic [DW-1:0] boot_disk_addr
);
  boot_state_e state;
  logic        pend, take, commit;
  logic        req_fire, rsp_fire;

  assign req_fire = mem_req_valid & mem_req_ready;
  assign rsp_fire = mem_rsp_valid & mem_rsp_ready;

  boot_req_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_btn (boot_btn),
    .req_cmd (boot_cmd),
    .take    (take),
    .pend    (pend)
  );

  boot_step_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     (pend),
    .req_fire (req_fire),
    .rsp_fire (rsp_fire),
    .state    (state),
    .take     (take),
    .commit   (commit)
  );

  boot_bus_drv #(
    .AW(AW), .DW(DW),
    .PC_SAVE_ADDR(PC_SAVE_ADDR), .DISP_ADDR(DISP_ADDR), .KBD_ADDR(KBD_ADDR)
  ) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .take      (take),
    .pc_in     (pc_in),
    .req_valid (mem_req_valid),
    .req_we    (mem_req_we),
    .req_addr  (mem_req_addr),
    .req_wdata (mem_req_wdata),
    .rsp_ready (mem_rsp_ready),
    .irq_off   (irq_off)
  );

  boot_key_dec #(.DW(DW), .BOOT_KEY_BIT(BOOT_KEY_BIT)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .rsp_fire  (rsp_fire),
    .rsp_data  (mem_rsp_data),
    .commit    (commit),
    .done      (boot_done),
    .from_disk (boot_from_disk),
    .disk_addr (boot_disk_addr)
  );
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] PC_SAVE_ADDR = '0,
  parameter logic [AW-1:0] DISP_ADDR    = AW'(16'o420),
  parameter logic [AW-1:0] KBD_ADDR     = AW'(16'o177034)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_addr,
  input logic [DW-1:0] mem_req_wdata,
  input logic          irq_off,
  input logic          boot_done,
  input logic          boot_from_disk,
  input logic [DW-1:0] boot_disk_addr
);
  p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_we)
      && $stable(mem_req_addr) && $stable(mem_req_wdata)));

  p_write_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> (mem_req_addr == PC_SAVE_ADDR || mem_req_addr == DISP_ADDR));

  p_disp_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we && mem_req_addr == DISP_ADDR) |-> (mem_req_wdata == '0));

  p_read_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_we) |-> (mem_req_addr == KBD_ADDR));

  p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_off |=> !irq_off);

  p_irq_no_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_off |-> !mem_req_valid);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> !boot_done);

  p_hold_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(boot_disk_addr) || !$stable(boot_from_disk)) |-> boot_done);

  p_nodisk_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && !boot_from_disk) |-> (boot_disk_addr == '0));
endmodule

bind boot_seq boot_seq_chk #(
  .AW(AW), .DW(DW),
  .PC_SAVE_ADDR(PC_SAVE_ADDR), .DISP_ADDR(DISP_ADDR), .KBD_ADDR(KBD_ADDR)
) u_chk (.*);

// File: tb/test_boot_seq.sv
`timescale 1ns/1ps
module test_boot_seq;
  localparam logic [15:0] DISP = 16'h0110;
  localparam logic [15:0] KBD  = 16'hFE1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_btn = 1'b0, boot_cmd = 1'b0;
  logic [15:0] pc_in = '0;
  logic        mem_req_valid, mem_req_ready = 1'b0, mem_req_we;
  logic [15:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0, mem_rsp_ready;
  logic [15:0] mem_rsp_data = '0;
  logic        irq_off, boot_done, boot_from_disk;
  logic [15:0] boot_disk_addr;

  int checks = 0, errors = 0;
  int stall = 0, rsp_delay = 0;
  logic [15:0] kbd_word = 16'hFFFF;

  typedef struct {
    int          kind;   // 0 write, 1 read, 2 irq pulse, 3 done
    logic [15:0] a;
    logic [15:0] d;
    string       req;
  } item_t;
  item_t exp_q[$];

  always #10 clk = ~clk;

  boot_seq i_boot_seq (
    .clk(clk), .rst_n(rst_n), .boot_btn(boot_btn), .boot_cmd(boot_cmd), .pc_in(pc_in),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .irq_off(irq_off), .boot_done(boot_done), .boot_from_disk(boot_from_disk),
    .boot_disk_addr(boot_disk_addr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory request acceptance with a programmable stall
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_req_ready) begin
        mem_req_ready = 1'b0;
        cnt = 0;
      end else if (mem_req_valid) begin
        if (cnt >= stall) mem_req_ready = 1'b1;
        else cnt++;
      end
    end
  end

  // read response after a programmable delay once the controller waits
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_rsp_valid) begin
        mem_rsp_valid = 1'b0;
        cnt = 0;
      end else if (mem_rsp_ready) begin
        if (cnt >= rsp_delay) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = kbd_word;
        end else cnt++;
      end
    end
  end

  task automatic expect_item(input item_t it, input int kind, input logic [15:0] a,
                             input logic [15:0] d, input bit we_ok);
    string what;
    what = $sformatf("event kind %0d", kind);
    check(it.kind == kind && we_ok, it.req, what, {kind[3:0], a, d[11:0]},
          {it.kind[3:0], it.a, it.d[11:0]});
    if (it.kind == kind)
      check(a == it.a && d == it.d, it.req, "event value", {a, d}, {it.a, it.d});
  endtask

  // monitor: compare observed events against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R9", "unexpected bus transfer", mem_req_addr, 0);
        else if (mem_req_we) expect_item(exp_q.pop_front(), 0, mem_req_addr, mem_req_wdata, 1'b1);
        else expect_item(exp_q.pop_front(), 1, mem_req_addr, 16'h0, 1'b1);
      end
      if (rst_n && irq_off) begin
        if (exp_q.size() == 0) check(1'b0, "R4", "unexpected irq pulse", 1, 0);
        else expect_item(exp_q.pop_front(), 2, 16'h0, 16'h0, 1'b1);
      end
      if (rst_n && boot_done) begin
        if (exp_q.size() == 0) check(1'b0, "R10", "unexpected done", boot_disk_addr, 0);
        else expect_item(exp_q.pop_front(), 3, boot_disk_addr, {15'h0, boot_from_disk}, 1'b1);
      end
    end
  end

  function automatic item_t mk(input int kind, input logic [15:0] a,
                               input logic [15:0] d, input string req);
    item_t it;
    it.kind = kind; it.a = a; it.d = d; it.req = req;
    return it;
  endfunction

  task automatic push_script(input logic [15:0] pc);
    exp_q.push_back(mk(0, 16'h0000, pc, "R2"));   // PC saved to word 0
    exp_q.push_back(mk(0, DISP, 16'h0, "R3"));    // display blanked
    exp_q.push_back(mk(2, 16'h0, 16'h0, "R4"));   // interrupts off
    exp_q.push_back(mk(1, KBD, 16'h0, "R5"));     // keyboard read
  endtask

  task automatic push_done(input logic [15:0] addr, input bit disk, input string req);
    exp_q.push_back(mk(3, addr, {15'h0, disk}, req));
  endtask

  task automatic pulse(input bit use_cmd);
    if (use_cmd) boot_cmd = 1'b1; else boot_btn = 1'b1;
    @(negedge clk);
    boot_cmd = 1'b0; boot_btn = 1'b0;
  endtask

  task automatic drain(input string req);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, req, "scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!mem_req_valid, "R1", "req valid", mem_req_valid, 0);
    check(!irq_off && !boot_done, "R1", "irq/done", {irq_off, boot_done}, 0);
    check(boot_disk_addr == 0 && !boot_from_disk, "R1", "result", boot_disk_addr, 0);

    // R7 button boot, idle keyboard
    stall = 0; rsp_delay = 0; kbd_word = 16'hFFFF; pc_in = 16'h1234;
    push_script(16'h1234); push_done(16'h0000, 1'b1, "R7");
    pulse(1'b0);
    drain("R7");

    // R6 command boot, some keys held, stalls on both channels
    stall = 2; rsp_delay = 3; kbd_word = 16'hA5F0; pc_in = 16'hBEEF;
    push_script(16'hBEEF); push_done(16'h5A0F, 1'b1, "R6");
    pulse(1'b1);
    drain("R6");

    // R11 outputs hold while idle
    repeat (10) @(negedge clk);
    check(boot_disk_addr == 16'h5A0F && boot_from_disk, "R11", "held result",
          boot_disk_addr, 16'h5A0F);

    // R8 select key held
    stall = 1; rsp_delay = 1; kbd_word = 16'h7FFE; pc_in = 16'h0042;
    push_script(16'h0042); push_done(16'h0000, 1'b0, "R8");
    pulse(1'b0);
    drain("R8");

    // R10 restart during stalled display write
    stall = 8; rsp_delay = 0; kbd_word = 16'hFFF3; pc_in = 16'h1111;
    exp_q.push_back(mk(0, 16'h0000, 16'h1111, "R10"));
    exp_q.push_back(mk(0, DISP, 16'h0, "R10"));
    pulse(1'b1);
    while (!(mem_req_valid && mem_req_addr == DISP)) @(negedge clk);
    pc_in = 16'h2222;
    push_script(16'h2222); push_done(16'h000C, 1'b1, "R10");
    pulse(1'b0);
    drain("R10");

    // R10 restart while waiting for the keyboard response
    stall = 0; rsp_delay = 6; kbd_word = 16'hFFFE; pc_in = 16'h3333;
    push_script(16'h3333);
    pulse(1'b0);
    while (!mem_rsp_ready) @(negedge clk);
    pc_in = 16'h4444;
    push_script(16'h4444); push_done(16'h0001, 1'b1, "R10");
    pulse(1'b1);
    drain("R10");
    check(boot_disk_addr == 16'h0001, "R11", "final result", boot_disk_addr, 16'h0001);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule